// File: doc/BRIEF.md
# Router Test Flit Generator

This block produces a fixed, repeatable sequence of 34-bit test flits for the structural test of a five-port wormhole router with two virtual channels, and of the links between routers. Each flit is built from 17 two-bit digits. Every digit in a field carries the same value, so each pattern is symmetric across all of the 1-of-4 symbols of a link. The block has two modes. In link mode it emits four vectors. In router mode it walks every combination of injection port, output direction and virtual channel, and emits eight framed flits for each combination.

Flits leave on a valid/ready stream. Each flit carries a virtual-channel tag, a send tag and an injection-port tag. `out_valid` stays high from the cycle after `start` until the last flit is accepted. The sequence moves to the next flit only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the flit and all of its tags hold their values, so a consumer can apply back-pressure for any length of time. When the last flit is taken, `out_valid` falls and `done` rises. A new `start` pulse, even one in the middle of a run, begins again from the first vector and uses the mode present on `link_mode` at that edge.

Top module: `tfg`

## Requirements
- R1: After reset, `out_valid` and `done` are both 0, and they stay 0 until `start` is seen.
- R2: A `start` pulse makes `out_valid` 1 in the next cycle and clears `done`. The first flit is vector 0 of the chosen mode. This also applies when the pulse arrives during a run.
- R3: The sequence advances only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_flit`, `out_vc`, `out_send` and `out_port` hold their values.
- R4: Link mode emits exactly 4 flits. Flit k has all 17 digits equal to k. On these flits `out_vc` and `out_port` are 0, and `out_send` is k mod 2, so the send tag alternates 0,1,0,1.
- R5: Router mode emits 5×4×2×8 = 320 flits. The loop order, from outermost to innermost, is injection port (0..4, shown on `out_port`), then direction (0..3), then virtual channel (0..1), then vector (0..7).
- R6: Bits 33:32 hold the frame code: 01 header, 00 body, 10 tail, 11 single-flit packet. For vectors 0..7 the (frame code, digit) pairs are: (01,1), (00,0), (10,3), (01,2), (00,1), (10,2), (01,3), (10,0).
- R7: A header flit carries the direction in bits 1:0 and the vector's digit in every digit of bits 31:2. A body or tail flit carries the vector's digit in every digit of bits 31:0.
- R8: In router mode `out_vc` equals the virtual-channel index and `out_send` equals it too.
- R9: When the last flit is accepted, `out_valid` falls in the next cycle and `done` rises. `done` stays high until the next `start`, and `out_valid` and `done` are never high together.
- R10: `link_mode` is sampled only on the `start` cycle. A change on `link_mode` during a run has no effect on the flits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that starts or restarts the sequence |
| link_mode | input | 1 | Mode select, sampled on `start`: 1 for the link test, 0 for the router test |
| out_ready | input | 1 | The consumer accepts the current flit |
| out_valid | output | 1 | A flit is on offer |
| out_flit | output | 34 | Test flit |
| out_vc | output | 1 | Virtual-channel tag |
| out_send | output | 1 | Send-channel tag |
| out_port | output | 3 | Injection-port tag |
| done | output | 1 | The whole sequence has been accepted |

## Verification
The condition hardest to reach is a combination of three events: a restart in the middle of a router run, a mode change while flits are in flight, and long stalls that fall on the boundaries between triplets. The stimulus walks all 320 router flits while a fixed rhythm drops `out_ready`, so stalls land on every position of the nested counters. During the run it flips `link_mode`. It then restarts the router sequence after ten accepted flits, this time in link mode, and expects link vector 0 at once.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  localparam int FLIT_W  = 34;
  localparam int DIGITS  = FLIT_W / 2;
  localparam int VEC_RTR = 8;

  typedef enum logic [1:0] {
    FR_BODY   = 2'b00,
    FR_HEAD   = 2'b01,
    FR_TAIL   = 2'b10,
    FR_SINGLE = 2'b11
  } frame_e;

  // frame code chosen for each of the eight vectors in a triplet
  function automatic frame_e vec_frame(input logic [2:0] v);
    case (v)
      3'd0, 3'd3, 3'd6: return FR_HEAD;
      3'd1, 3'd4:       return FR_BODY;
      default:          return FR_TAIL;
    endcase
  endfunction

  // digit value repeated across the flit for each vector
  function automatic logic [1:0] vec_digit(input logic [2:0] v);
    case (v)
      3'd0:    return 2'd1;
      3'd1:    return 2'd0;
      3'd2:    return 2'd3;
      3'd3:    return 2'd2;
      3'd4:    return 2'd1;
      3'd5:    return 2'd2;
      3'd6:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tfg_seq.sv
module tfg_seq #(
  parameter int NUM_IN   = 5,
  parameter int NUM_DIR  = 4,
  parameter int NUM_VC   = 2,
  parameter int VEC_RTR  = 8,
  parameter int VEC_LINK = 4,
  localparam int IW  = $clog2(NUM_IN),
  localparam int DW  = $clog2(NUM_DIR),
  localparam int CW  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int VW  = $clog2((VEC_RTR > VEC_LINK) ? VEC_RTR : VEC_LINK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_mode,
  input  logic          adv,
  output logic          running,
  output logic          done,
  output logic          lmode,
  output logic [IW-1:0] cnt_in,
  output logic [DW-1:0] cnt_dir,
  output logic [CW-1:0] cnt_vc,
  output logic [VW-1:0] cnt_vec
);
  logic last_vec, last_vc, last_dir, last_in, last_all;

  always_comb begin
    last_vec = lmode ? (cnt_vec == VW'(VEC_LINK - 1)) : (cnt_vec == VW'(VEC_RTR - 1));
    last_vc  = (cnt_vc  == CW'(NUM_VC - 1));
    last_dir = (cnt_dir == DW'(NUM_DIR - 1));
    last_in  = (cnt_in  == IW'(NUM_IN - 1));
    last_all = last_vec && (lmode || (last_vc && last_dir && last_in));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      lmode   <= 1'b0;
      cnt_in  <= '0;
      cnt_dir <= '0;
      cnt_vc  <= '0;
      cnt_vec <= '0;
    end else if (start) begin
      running <= 1'b1;
      done    <= 1'b0;
      lmode   <= link_mode;
      cnt_in  <= '0;
      cnt_dir <= '0;
      cnt_vc  <= '0;
      cnt_vec <= '0;
    end else if (adv) begin
      if (last_all) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (!last_vec) begin
        cnt_vec <= cnt_vec + 1'b1;
      end else begin
        cnt_vec <= '0;
        if (!last_vc) begin
          cnt_vc <= cnt_vc + 1'b1;
        end else begin
          cnt_vc <= '0;
          if (!last_dir) begin
            cnt_dir <= cnt_dir + 1'b1;
          end else begin
            cnt_dir <= '0;
            cnt_in  <= cnt_in + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tfg_fmt.sv
module tfg_fmt
  import tfg_pkg::*;
#(
  parameter int NUM_IN  = 5,
  parameter int NUM_DIR = 4,
  parameter int NUM_VC  = 2,
  parameter int VW      = 3,
  localparam int IW = $clog2(NUM_IN),
  localparam int DW = $clog2(NUM_DIR),
  localparam int CW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              lmode,
  input  logic [IW-1:0]     cnt_in,
  input  logic [DW-1:0]     cnt_dir,
  input  logic [CW-1:0]     cnt_vc,
  input  logic [VW-1:0]     cnt_vec,
  output logic [FLIT_W-1:0] flit,
  output logic [CW-1:0]     vc,
  output logic              send,
  output logic [IW-1:0]     port
);
  logic [FLIT_W-1:0] link_flit, rtr_flit;
  frame_e            fr;
  logic [1:0]        dig;

  assign fr  = vec_frame(3'(cnt_vec));
  assign dig = vec_digit(3'(cnt_vec));

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_link
      assign link_flit[2*g +: 2] = cnt_vec[1:0];
    end
    for (g = 1; g < DIGITS - 1; g++) begin : g_rtr
      assign rtr_flit[2*g +: 2] = dig;
    end
  endgenerate

  assign rtr_flit[FLIT_W-1 -: 2] = fr;
  assign rtr_flit[1:0]           = (fr == FR_HEAD) ? 2'(cnt_dir) : dig;

  always_comb begin
    flit = lmode ? link_flit : rtr_flit;
    vc   = lmode ? '0 : cnt_vc;
    send = lmode ? cnt_vec[0] : cnt_vc[0];
    port = lmode ? '0 : cnt_in;
  end
endmodule

// File: rtl/tfg.sv
module tfg
  import tfg_pkg::*;
#(
  parameter int NUM_IN   = 5,
  parameter int NUM_DIR  = 4,
  parameter int NUM_VC   = 2,
  parameter int VEC_LINK = 4,
  localparam int IW = $clog2(NUM_IN),
  localparam int CW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int DW = $clog2(NUM_DIR),
  localparam int VW = $clog2((VEC_RTR > VEC_LINK) ? VEC_RTR : VEC_LINK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              link_mode,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  output logic [CW-1:0]     out_vc,
  output logic              out_send,
  output logic [IW-1:0]     out_port,
  output logic              done
);
  logic          running, seq_lmode;
  logic [IW-1:0] cnt_in;
  logic [DW-1:0] cnt_dir;
  logic [CW-1:0] cnt_vc;
  logic [VW-1:0] cnt_vec;

  tfg_seq #(
    .NUM_IN(NUM_IN), .NUM_DIR(NUM_DIR), .NUM_VC(NUM_VC),
    .VEC_RTR(VEC_RTR), .VEC_LINK(VEC_LINK)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .link_mode(link_mode),
    .adv(running && out_ready), .running(running), .done(done),
    .lmode(seq_lmode), .cnt_in(cnt_in), .cnt_dir(cnt_dir),
    .cnt_vc(cnt_vc), .cnt_vec(cnt_vec)
  );

  tfg_fmt #(
    .NUM_IN(NUM_IN), .NUM_DIR(NUM_DIR), .NUM_VC(NUM_VC), .VW(VW)
  ) fmt_i (
    .lmode(seq_lmode), .cnt_in(cnt_in), .cnt_dir(cnt_dir),
    .cnt_vc(cnt_vc), .cnt_vec(cnt_vec), .flit(out_flit),
    .vc(out_vc), .send(out_send), .port(out_port)
  );

  assign out_valid = running;
endmodule

// File: rtl/tfg_chk.sv
module tfg_chk
  import tfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              out_ready,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit,
  input logic              out_send,
  input logic              done,
  input logic              lmode
);
  logic sym;
  always_comb begin
    sym = 1'b1;
    for (int k = 1; k < DIGITS; k++)
      if (out_flit[2*k +: 2] != out_flit[1:0]) sym = 1'b0;
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_flit) && $stable(out_send));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid && !done);

  // R4
  link_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && lmode && !start |=> !out_valid || (out_send != $past(out_send)));

  // R4
  link_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lmode |-> sym);
endmodule

bind tfg tfg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_flit(out_flit), .out_send(out_send),
  .done(done), .lmode(seq_lmode)
);

// File: tb/tfg_tb_top.sv
module tfg_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, link_mode = 0, out_ready = 0;
  logic        out_valid, out_send, done;
  logic [33:0] out_flit;
  logic [0:0]  out_vc;
  logic [2:0]  out_port;
  int n_chk = 0, n_fail = 0, cyc = 0;

  // per-vector {frame code, digit}: R6 table
  localparam logic [3:0] VT [8] = '{4'b0101, 4'b0000, 4'b1011, 4'b0110,
                                    4'b0001, 4'b1010, 4'b0111, 4'b1000};

  always #4 clk = ~clk;

  tfg dut_i (.clk(clk), .rst_n(rst_n), .start(start), .link_mode(link_mode),
    .out_ready(out_ready), .out_valid(out_valid), .out_flit(out_flit),
    .out_vc(out_vc), .out_send(out_send), .out_port(out_port), .done(done));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [33:0] exp_flit(input bit lk, input int d, input int j);
    logic [1:0] be, dg;
    if (lk) return {17{2'(j)}};
    be = VT[j][3:2];
    dg = VT[j][1:0];
    return {be, {15{dg}}, (be == 2'b01) ? 2'(d) : dg};
  endfunction

  task automatic step(input logic r);
    @(negedge clk);
    out_ready = r;
    #1;
  endtask

  task automatic kick(input logic lk);
    @(negedge clk);
    start = 1; link_mode = lk; out_ready = 0;
    @(negedge clk);
    start = 0;
    #1;
    chk(out_valid === 1'b1 && done === 1'b0, "R2 start", {out_valid, done}, 2'b10);
  endtask

  // expects one flit; stalls per rhythm; checks hold on stall (R3)
  task automatic take(input bit lk, input int i, input int d, input int v, input int j, input string rq);
    logic [33:0] e;
    bit r;
    e = exp_flit(lk, d, j);
    forever begin
      cyc++;
      r = (cyc % 3) != 2;
      step(r);
      chk(out_valid === 1'b1 && out_flit === e, r ? rq : "R3 stall hold", out_flit, e);
      chk(out_vc === (lk ? 1'b0 : 1'(v)) && out_send === (lk ? 1'(j) : 1'(v)),
          lk ? "R4 tags" : "R8 tags", {out_vc, out_send}, lk ? {1'b0, 1'(j)} : {1'(v), 1'(v)});
      chk(out_port === (lk ? 3'd0 : 3'(i)), "R5 port", out_port, lk ? 0 : i);
      if (r) break;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk(out_valid === 1'b0 && done === 1'b0, "R1 reset", {out_valid, done}, 0);
    #20 rst_n = 1;
    repeat (3) step(1);
    chk(out_valid === 1'b0 && done === 1'b0, "R1 idle", {out_valid, done}, 0);

    // R4 link test
    kick(1);
    for (int k = 0; k < 4; k++) take(1, 0, 0, 0, k, "R4 link");
    step(1);
    chk(out_valid === 1'b0 && done === 1'b1, "R9 link done", {out_valid, done}, 2'b01);
    repeat (2) step(1);
    chk(done === 1'b1, "R9 done held", done, 1);

    // R5/R6/R7 router test, with link_mode toggled mid-run (R10)
    kick(0);
    for (int i = 0; i < 5; i++)
      for (int d = 0; d < 4; d++)
        for (int v = 0; v < 2; v++)
          for (int j = 0; j < 8; j++) begin
            if (i == 2 && d == 1) link_mode = 1;
            take(0, i, d, v, j, (j == 0 || j == 3 || j == 6) ? "R7 header" : "R6 frame");
          end
    step(1);
    chk(out_valid === 1'b0 && done === 1'b1, "R9 router done after 320", {out_valid, done}, 2'b01);

    // R2 restart mid-run in the other mode
    kick(0);
    for (int j = 0; j < 8; j++) take(0, 0, 0, 0, j, "R5 order");
    take(0, 0, 0, 1, 0, "R5 order");
    take(0, 0, 0, 1, 1, "R5 order");
    kick(1);
    chk(out_flit === 34'd0 && out_send === 1'b0, "R2 restart vector0", out_flit, 0);
    for (int k = 0; k < 4; k++) take(1, 0, 0, 0, k, "R2 restart link");
    step(1);
    chk(out_valid === 1'b0 && done === 1'b1, "R9 restart done", {out_valid, done}, 2'b01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule